// File: doc/BRIEF.md
# Fault Record Logger and Spare-Row Remapper

This block sits next to a March-style memory self-test engine. Whenever the engine flags a miscompare, the block files a record. The record holds the failing row address, the word that was actually read, and the index of the March element that was running when the fault was seen. The records wait in a small first-in first-out store. An external tester pulls them out one bit per shift-enable cycle on a single serial line, so it can analyse the faults afterwards against the algorithm.

The same failure reports also build a repair table. Each new failing address claims the next free spare row. An address that already has a spare claims nothing more. In mission mode the block compares every access row address against the table, without a clock in the path. On a match it replaces the row address with the spare row number and raises a spare-select line, so the faulty row is served by redundant storage rather than masked.

Top module: `diag_repair_unit`

## Requirements
- R1: While reset is held and right after it is released, `rec_avail`, `ser_out`, `log_overflow`, `repair_fail` and `spare_sel` are 0, and `mission_row` equals `mission_addr`.
- R2: A `fail_valid` sampled at a rising edge while fewer than 8 records are stored appends the record {address, data, element}. `rec_avail` is 1 from the following cycle.
- R3: A `fail_valid` sampled while 8 records are stored is dropped, and `log_overflow` is 1 from the next cycle and stays 1 until reset. The count of 8 is the count before any removal at that same edge.
- R4: `ser_out` shows one bit of the oldest record, MSB first. The order is address bits (MSB down), then data bits, then element bits. Each edge with `shift_en` high moves on one bit. After 20 shifts the record is removed and the next record starts at its MSB.
- R5: Records leave in the order their failures arrived.
- R6: With no record stored, `shift_en` has no effect and `ser_out` is 0.
- R7: A failing address not yet in the table takes the next free spare, in the order 0, 1, 2, 3, from the next cycle.
- R8: A failing address already in the table takes no new spare.
- R9: A new failing address that arrives when all 4 spares are taken is not mapped, and `repair_fail` is 1 from the next cycle and stays 1 until reset.
- R10: If `mission_addr` matches a table entry, then in the same cycle `mission_row` carries that spare's index, zero-extended, and `spare_sel` is 1. Otherwise `mission_row` equals `mission_addr` and `spare_sel` is 0.
- R11: A failure is logged whether or not its address is already mapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fail_valid | input | 1 | Self-test engine reports a miscompare this cycle |
| fail_addr | input | AW | Failing row address |
| fail_data | input | DW | Word read from the failing row |
| fail_elem | input | EW | March element index that detected the fault |
| shift_en | input | 1 | Tester advances the serial unload by one bit |
| ser_out | output | 1 | Current serial bit of the oldest record |
| rec_avail | output | 1 | At least one record is stored |
| log_overflow | output | 1 | Sticky: a record was dropped because the store was full |
| mission_addr | input | AW | Mission-mode access row address |
| mission_row | output | AW | Row address after remapping |
| spare_sel | output | 1 | Access is steered to a spare row |
| repair_fail | output | 1 | Sticky: a failing address found no free spare |

## Verification
Anything that depends on a failure report or a shift is due one rising edge after the cycle in which the stimulus is held. That covers the stored records, the serial bit position, both sticky flags and the repair table. The spare lookup is combinational, so it is due in the same cycle as `mission_addr`. The bench drives every input just after a falling edge and compares all outputs 1 ns later against a queue-based model. The model is updated only at the following rising edge. A one-edge result is therefore always compared in the cycle after its stimulus, and a lookup result is compared in the cycle where its address is driven.

// File: rtl/diag_repair_pkg.sv
package diag_repair_pkg;
    localparam int unsigned DEF_AW     = 8;
    localparam int unsigned DEF_DW     = 8;
    localparam int unsigned DEF_EW     = 4;
    localparam int unsigned DEF_DEPTH  = 8;
    localparam int unsigned DEF_SPARES = 4;
endpackage

// File: rtl/fault_log.sv
module fault_log #(
    parameter int unsigned AW    = diag_repair_pkg::DEF_AW,
    parameter int unsigned DW    = diag_repair_pkg::DEF_DW,
    parameter int unsigned EW    = diag_repair_pkg::DEF_EW,
    parameter int unsigned DEPTH = diag_repair_pkg::DEF_DEPTH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic [EW-1:0] elem_i,
    input  logic          shift_i,
    output logic          bit_o,
    output logic          nonempty_o,
    output logic          overflow_o
);
    localparam int unsigned RW = AW + DW + EW;
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam int unsigned BW = (RW > 1) ? $clog2(RW) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][RW-1:0] mem;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [CW-1:0]            cnt;
        logic [BW-1:0]            bpos;
        logic                     ovf;
    } log_st_t;

    log_st_t st_d, st_q;
    logic    pop, put;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        put  = 1'b0;
        if (shift_i && st_q.cnt != '0) begin
            if (st_q.bpos == BW'(RW - 1)) begin
                st_d.bpos = '0;
                st_d.rd   = wrap_inc(st_q.rd);
                pop       = 1'b1;
            end else begin
                st_d.bpos = st_q.bpos + 1'b1;
            end
        end
        if (push_i) begin
            if (st_q.cnt != CW'(DEPTH)) begin
                st_d.mem[st_q.wr] = {addr_i, data_i, elem_i};
                st_d.wr           = wrap_inc(st_q.wr);
                put               = 1'b1;
            end else begin
                st_d.ovf = 1'b1;
            end
        end
        st_d.cnt = st_q.cnt + CW'(put) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_o      = (st_q.cnt != '0) ? st_q.mem[st_q.rd][BW'(RW - 1) - st_q.bpos] : 1'b0;
    assign nonempty_o = (st_q.cnt != '0);
    assign overflow_o = st_q.ovf;
endmodule

// File: rtl/remap_table.sv
module remap_table #(
    parameter int unsigned AW     = diag_repair_pkg::DEF_AW,
    parameter int unsigned SPARES = diag_repair_pkg::DEF_SPARES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fail_i,
    input  logic [AW-1:0] fail_addr_i,
    input  logic [AW-1:0] look_addr_i,
    output logic [AW-1:0] row_o,
    output logic          hit_o,
    output logic          full_fail_o
);
    localparam int unsigned SW = (SPARES > 1) ? $clog2(SPARES) : 1;
    localparam int unsigned UW = $clog2(SPARES + 1);

    typedef struct packed {
        logic [SPARES-1:0][AW-1:0] tag;
        logic [UW-1:0]             used;
        logic                      rfail;
    } map_st_t;

    map_st_t           st_d, st_q;
    logic [SPARES-1:0] fail_match, look_match;
    logic              look_hit;
    logic [SW-1:0]     look_idx;

    for (genvar i = 0; i < SPARES; i++) begin : g_cmp
        assign fail_match[i] = (UW'(i) < st_q.used) && (st_q.tag[i] == fail_addr_i);
        assign look_match[i] = (UW'(i) < st_q.used) && (st_q.tag[i] == look_addr_i);
    end

    always_comb begin
        look_hit = 1'b0;
        look_idx = '0;
        for (int i = 0; i < SPARES; i++) begin
            if (look_match[i] && !look_hit) begin
                look_hit = 1'b1;
                look_idx = SW'(i);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (fail_i && fail_match == '0) begin
            if (st_q.used != UW'(SPARES)) begin
                st_d.tag[SW'(st_q.used)] = fail_addr_i;
                st_d.used                = st_q.used + 1'b1;
            end else begin
                st_d.rfail = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit_o       = look_hit;
    assign row_o       = look_hit ? AW'(look_idx) : look_addr_i;
    assign full_fail_o = st_q.rfail;
endmodule

// File: rtl/diag_repair_unit.sv
module diag_repair_unit #(
    parameter int unsigned AW     = diag_repair_pkg::DEF_AW,
    parameter int unsigned DW     = diag_repair_pkg::DEF_DW,
    parameter int unsigned EW     = diag_repair_pkg::DEF_EW,
    parameter int unsigned DEPTH  = diag_repair_pkg::DEF_DEPTH,
    parameter int unsigned SPARES = diag_repair_pkg::DEF_SPARES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fail_valid,
    input  logic [AW-1:0] fail_addr,
    input  logic [DW-1:0] fail_data,
    input  logic [EW-1:0] fail_elem,
    input  logic          shift_en,
    output logic          ser_out,
    output logic          rec_avail,
    output logic          log_overflow,
    input  logic [AW-1:0] mission_addr,
    output logic [AW-1:0] mission_row,
    output logic          spare_sel,
    output logic          repair_fail
);
    fault_log #(.AW(AW), .DW(DW), .EW(EW), .DEPTH(DEPTH)) log_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (fail_valid),
        .addr_i     (fail_addr),
        .data_i     (fail_data),
        .elem_i     (fail_elem),
        .shift_i    (shift_en),
        .bit_o      (ser_out),
        .nonempty_o (rec_avail),
        .overflow_o (log_overflow)
    );

    remap_table #(.AW(AW), .SPARES(SPARES)) map_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fail_i      (fail_valid),
        .fail_addr_i (fail_addr),
        .look_addr_i (mission_addr),
        .row_o       (mission_row),
        .hit_o       (spare_sel),
        .full_fail_o (repair_fail)
    );
endmodule

// File: rtl/diag_repair_chk.sv
module diag_repair_chk #(
    parameter int unsigned AW     = 8,
    parameter int unsigned SPARES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fail_valid,
    input logic          ser_out,
    input logic          rec_avail,
    input logic          log_overflow,
    input logic [AW-1:0] mission_addr,
    input logic [AW-1:0] mission_row,
    input logic          spare_sel,
    input logic          repair_fail
);
    assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fail_valid |=> rec_avail);

    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        log_overflow |=> log_overflow);

    assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(log_overflow) |-> ($past(fail_valid) && $past(rec_avail)));

    assert_empty_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_avail |-> !ser_out);

    assert_rfail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        repair_fail |=> repair_fail);

    assert_rfail_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(repair_fail) |-> $past(fail_valid));

    assert_spare_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spare_sel |-> (32'(mission_row) < SPARES));

    assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !spare_sel |-> (mission_row == mission_addr));
endmodule

bind diag_repair_unit diag_repair_chk #(.AW(AW), .SPARES(SPARES)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .fail_valid   (fail_valid),
    .ser_out      (ser_out),
    .rec_avail    (rec_avail),
    .log_overflow (log_overflow),
    .mission_addr (mission_addr),
    .mission_row  (mission_row),
    .spare_sel    (spare_sel),
    .repair_fail  (repair_fail)
);

// File: tb/diag_repair_unit_tb_top.sv
`timescale 1ns/1ps
module diag_repair_unit_tb_top;
    localparam int AW = 8, DW = 8, EW = 4, RW = 20, DEPTH = 8, SPARES = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fail_valid = 1'b0;
    logic [AW-1:0] fail_addr = '0;
    logic [DW-1:0] fail_data = '0;
    logic [EW-1:0] fail_elem = '0;
    logic          shift_en = 1'b0;
    logic          ser_out, rec_avail, log_overflow, spare_sel, repair_fail;
    logic [AW-1:0] mission_addr = 8'h5A;
    logic [AW-1:0] mission_row;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // behavioural reference
    logic [RW-1:0] recq[$];
    logic [AW-1:0] tagq[$];
    int  bitpos = 0;
    bit  m_ovf = 0, m_rfail = 0;

    always #2.5 clk = ~clk;

    diag_repair_unit dut_i (
        .clk(clk), .rst_n(rst_n), .fail_valid(fail_valid), .fail_addr(fail_addr),
        .fail_data(fail_data), .fail_elem(fail_elem), .shift_en(shift_en),
        .ser_out(ser_out), .rec_avail(rec_avail), .log_overflow(log_overflow),
        .mission_addr(mission_addr), .mission_row(mission_row),
        .spare_sel(spare_sel), .repair_fail(repair_fail)
    );

    task automatic chk1(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        logic          e_ser, e_sel;
        logic [AW-1:0] e_row;
        e_ser = (recq.size() > 0) ? recq[0][RW-1-bitpos] : 1'b0;
        e_sel = 1'b0;
        e_row = mission_addr;
        foreach (tagq[i]) if (tagq[i] == mission_addr && !e_sel) begin
            e_sel = 1'b1;
            e_row = AW'(i);
        end
        chk1("R4/R5/R6 ser_out", 32'(ser_out), 32'(e_ser));
        chk1("R2 rec_avail", 32'(rec_avail), 32'(recq.size() > 0));
        chk1("R3 log_overflow", 32'(log_overflow), 32'(m_ovf));
        chk1("R9 repair_fail", 32'(repair_fail), 32'(m_rfail));
        chk1("R10 spare_sel (R7/R8 table)", 32'(spare_sel), 32'(e_sel));
        chk1("R10 mission_row (R7/R8 table)", 32'(mission_row), 32'(e_row));
    endtask

    task automatic model_edge();
        int  pre;
        bit  known;
        pre = recq.size();
        if (shift_en && pre > 0) begin
            bitpos++;
            if (bitpos == RW) begin
                void'(recq.pop_front());
                bitpos = 0;
            end
        end
        if (fail_valid) begin
            // R11: logging does not depend on the table
            if (pre < DEPTH) recq.push_back({fail_addr, fail_data, fail_elem});
            else m_ovf = 1;
            known = 0;
            foreach (tagq[i]) if (tagq[i] == fail_addr) known = 1;
            if (!known) begin
                if (tagq.size() < SPARES) tagq.push_back(fail_addr);
                else m_rfail = 1;
            end
        end
    endtask

    task automatic step(input bit fv, input logic [AW-1:0] fa, input logic [DW-1:0] fd,
                        input logic [EW-1:0] fe, input bit se, input logic [AW-1:0] ma);
        @(negedge clk);
        fail_valid = fv; fail_addr = fa; fail_data = fd; fail_elem = fe;
        shift_en = se; mission_addr = ma;
        #1;
        compare_all();
        @(posedge clk);
        model_edge();
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        compare_all();
        chk1("R1 mission_row passthrough in reset", 32'(mission_row), 32'h5A);
        @(negedge clk);
        rst_n = 1'b1;

        // R7 R8 R11: three distinct failing rows plus a repeat of 0x10
        step(1, 8'h10, 8'hA5, 4'd3, 0, 8'h10);
        step(0, 0, 0, 0, 0, 8'h10);
        step(1, 8'h22, 8'h3C, 4'd1, 0, 8'h22);
        step(1, 8'h10, 8'h0F, 4'd6, 0, 8'h10);
        step(1, 8'h81, 8'hFF, 4'd9, 0, 8'h33);
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 0, AW'(8'h0F + i * 8'h09));
        step(0, 0, 0, 0, 0, 8'h81);

        // R4 R5: unload with gaps in shift_en
        for (int i = 0; i < 100; i++) step(0, 0, 0, 0, (i % 7) != 3, AW'(i));
        // R6: shifting an empty store
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 8'h22);

        // R3 R9: flood with new rows, more than the store and the spares hold
        for (int i = 0; i < 11; i++)
            step(1, AW'(8'h40 + i), DW'(8'hC0 ^ i), EW'(i), 0, AW'(8'h40 + i));
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, AW'(8'h40 + i));

        // R2 R3 R5: unload while failures keep arriving
        for (int i = 0; i < 240; i++)
            step((i % 23) == 5, AW'(8'h10 + (i % 3)), DW'(i), EW'(i), 1, AW'(8'h3E + (i % 5)));

        // R10: lookup sweep
        for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, AW'(i * 5));
        step(0, 0, 0, 0, 0, 8'h10);
        step(0, 0, 0, 0, 0, 8'h81);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule